// File: doc/BRIEF.md
# Sliding Window Scan Controller

This block walks a square 20x20 window across a grayscale frame held row after row in an external memory. It visits window positions left to right along a band and then moves down one band, advancing by a parameterised stride each time. A position whose window would cross the right or bottom edge of the frame is skipped. For each position it computes every pixel address from a running pointer rather than a multiplier. It reads each pixel through a synchronous read port and hands the 400 pixels to a downstream classifier as one feature vector over a ready/valid stream, top row first and left to right within a row.

After the last pixel of a window, the block waits for the classifier's verdict on a result handshake. A positive verdict starts a short drawing sequence into a second frame memory that holds a copy of the image. The sequence paints a plus sign of full-scale pixels centred on the window. A negative verdict leaves that memory untouched. When the final position has been handled, a done flag rises and the block stays quiet until it is started again.

Top module: `win_scan_ctrl`

## Requirements
- R1: While and just after reset, rd_en, wr_en, pix_valid, pix_last, res_ready and done are all 0.
- R2: For each window at top-left (row y0, column x0), the block streams 400 pixels: row y0 first, then y0+1 and so on, each row taken left to right. Pixel k (0-based) is the byte stored at read address RD_BASE + (y0 + k/20) * IMG_W + (x0 + k%20). pix_last is 1 on pixel 399 only.
- R3: Window positions run in row order with step STRIDE in both directions, starting at (0,0). Only positions with x0 + 20 <= IMG_W and y0 + 20 <= IMG_H are visited. The defaults give 4 columns by 3 rows, so 12 windows.
- R4: While pix_valid is 1 and pix_ready is 0, pix_valid stays 1 and pix_data and pix_last do not change. Each accepted transfer consumes exactly one pixel.
- R5: res_ready rises in the cycle after the last pixel is accepted and stays 1 until res_valid is seen. No pixel is offered while res_ready is 1.
- R6: A result with res_hit = 1 produces exactly 9 writes of all-ones data. For window offset off = y0*IMG_W + x0 and centre cen = off + 10*IMG_W + 10, the write addresses are WR_BASE + cen + d and WR_BASE + cen + d*IMG_W for d in -2..2.
- R7: A result with res_hit = 0 produces no write, and the next window starts streaming.
- R8: rd_data is taken in the cycle after a one-cycle rd_en pulse. Each pixel is read exactly once, and rd_en and wr_en are never 1 in the same cycle.
- R9: done rises only after the result (and marker, if any) of the last window is handled. It stays 1 with no reads or writes until start.
- R10: start begins a scan from idle or from done, and done falls in the next cycle. start pulses during a scan are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a scan (idle or done only) |
| rd_en | output | 1 | Read strobe to source frame memory |
| rd_addr | output | ADDR_W | Read address |
| rd_data | input | PIX_W | Read data, valid one cycle after rd_en |
| pix_valid | output | 1 | Pixel offered to classifier |
| pix_ready | input | 1 | Classifier accepts pixel |
| pix_data | output | PIX_W | Pixel value |
| pix_last | output | 1 | Final pixel of the window |
| res_valid | input | 1 | Classifier verdict present |
| res_ready | output | 1 | Block waits for a verdict |
| res_hit | input | 1 | Verdict: 1 = positive |
| wr_en | output | 1 | Write strobe to marker frame memory |
| wr_addr | output | ADDR_W | Write address |
| wr_data | output | PIX_W | Write data (all ones) |
| done | output | 1 | All positions handled |

## Verification
On every cycle, the embedded assertions check several rules. A read and a write never coincide, and a read strobe lasts one cycle. A stalled pixel is held steady, and no pixel is offered while a verdict is pending. The block is silent once done. Every window position lies inside the frame, the pixel counter never steps past the last pixel, and a marker never starts while one is drawing. Only the bench's scenarios can show the rest: that each pixel value and its order match the frame, that markers land on the right nine locations only for positive windows, that the window count is right when positions are skipped at the edges, and that done and restart behave as required.

// File: rtl/wsc_pkg.sv
package wsc_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LOAD,
    ST_RD,
    ST_CAP,
    ST_OUT,
    ST_WAIT,
    ST_MARK,
    ST_NEXT,
    ST_DONE
  } scan_state_t;
endpackage

// File: rtl/wsc_pos_gen.sv
module wsc_pos_gen #(
  parameter int IMG_W  = 34,
  parameter int IMG_H  = 29,
  parameter int WIN    = 20,
  parameter int STRIDE = 4,
  parameter int OFF_W  = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init,
  input  logic             adv,
  output logic [OFF_W-1:0] win_off,
  output logic             last
);
  localparam int NCOL = (IMG_W - WIN) / STRIDE + 1;
  localparam int NROW = (IMG_H - WIN) / STRIDE + 1;
  localparam int CW   = (NCOL > 1) ? $clog2(NCOL) : 1;
  localparam int RW   = (NROW > 1) ? $clog2(NROW) : 1;

  logic [CW-1:0]    col_idx;
  logic [RW-1:0]    row_idx;
  logic [OFF_W-1:0] row_off;

  wire col_end = (col_idx == CW'(NCOL - 1));
  assign last = col_end && (row_idx == RW'(NROW - 1));

  always_ff @(posedge clk) begin
    if (rst || init) begin
      col_idx <= '0;
      row_idx <= '0;
      row_off <= '0;
      win_off <= '0;
    end else if (adv) begin
      if (col_end) begin
        col_idx <= '0;
        row_idx <= row_idx + 1'b1;
        row_off <= row_off + OFF_W'(STRIDE * IMG_W);
        win_off <= row_off + OFF_W'(STRIDE * IMG_W);
      end else begin
        col_idx <= col_idx + 1'b1;
        win_off <= win_off + OFF_W'(STRIDE);
      end
    end
  end

  // Window must lie fully inside the frame (R3)
  assert_win_in_frame_R3: assert property (@(posedge clk) disable iff (rst)
    ((int'(win_off) % IMG_W) + WIN <= IMG_W) &&
    ((int'(win_off) / IMG_W) + WIN <= IMG_H));

  assert_adv_not_last_R3: assert property (@(posedge clk) disable iff (rst)
    adv |-> !last);
endmodule

// File: rtl/wsc_pix_gen.sv
module wsc_pix_gen #(
  parameter int IMG_W   = 34,
  parameter int WIN     = 20,
  parameter int ADDR_W  = 11,
  parameter int OFF_W   = 10,
  parameter int RD_BASE = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              step,
  input  logic [OFF_W-1:0]  win_off,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              last
);
  localparam int RCW = $clog2(WIN);

  logic [RCW-1:0] r_cnt;
  logic [RCW-1:0] c_cnt;

  wire row_end = (c_cnt == RCW'(WIN - 1));
  assign last = row_end && (r_cnt == RCW'(WIN - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      r_cnt   <= '0;
      c_cnt   <= '0;
      rd_addr <= '0;
    end else if (load) begin
      r_cnt   <= '0;
      c_cnt   <= '0;
      rd_addr <= ADDR_W'(RD_BASE) + ADDR_W'(win_off);
    end else if (step) begin
      if (row_end) begin
        c_cnt   <= '0;
        r_cnt   <= r_cnt + 1'b1;
        rd_addr <= rd_addr + ADDR_W'(IMG_W - WIN + 1);
      end else begin
        c_cnt   <= c_cnt + 1'b1;
        rd_addr <= rd_addr + 1'b1;
      end
    end
  end

  // The controller never steps past the final pixel (R2)
  assert_step_in_window_R2: assert property (@(posedge clk) disable iff (rst)
    step |-> !last);
endmodule

// File: rtl/wsc_marker.sv
module wsc_marker #(
  parameter int IMG_W   = 34,
  parameter int WIN     = 20,
  parameter int ARM     = 2,
  parameter int ADDR_W  = 11,
  parameter int OFF_W   = 10,
  parameter int WR_BASE = 100,
  parameter int PIX_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [OFF_W-1:0]  win_off,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              fin
);
  localparam int CEN = (WIN / 2) * IMG_W + (WIN / 2);
  localparam int H0  = CEN - ARM;
  localparam int V0  = CEN - ARM * IMG_W;
  localparam int NW  = 4 * ARM + 1;
  localparam int KW  = $clog2(NW);

  logic          busy;
  logic [KW-1:0] k;
  logic [ADDR_W-1:0] next_addr;

  assign wr_data = {PIX_W{1'b1}};
  assign fin     = busy && (k == KW'(NW - 1));

  always_comb begin
    if (int'(k) < 2 * ARM)
      next_addr = wr_addr + 1'b1;
    else if (int'(k) == 2 * ARM)
      next_addr = ADDR_W'(WR_BASE) + ADDR_W'(win_off) + ADDR_W'(V0);
    else if (int'(k) == 3 * ARM)
      next_addr = wr_addr + ADDR_W'(2 * IMG_W);
    else
      next_addr = wr_addr + ADDR_W'(IMG_W);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      wr_en   <= 1'b0;
      k       <= '0;
      wr_addr <= '0;
    end else if (start) begin
      busy    <= 1'b1;
      wr_en   <= 1'b1;
      k       <= '0;
      wr_addr <= ADDR_W'(WR_BASE) + ADDR_W'(win_off) + ADDR_W'(H0);
    end else if (busy) begin
      if (fin) begin
        busy  <= 1'b0;
        wr_en <= 1'b0;
      end else begin
        k       <= k + 1'b1;
        wr_addr <= next_addr;
      end
    end
  end

  // A new marker may only start once the previous one is finished (R6)
  assert_start_idle_R6: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
endmodule

// File: rtl/win_scan_ctrl.sv
module win_scan_ctrl
  import wsc_pkg::*;
#(
  parameter int IMG_W   = 34,
  parameter int IMG_H   = 29,
  parameter int WIN     = 20,
  parameter int STRIDE  = 4,
  parameter int ARM     = 2,
  parameter int PIX_W   = 8,
  parameter int ADDR_W  = 11,
  parameter int RD_BASE = 64,
  parameter int WR_BASE = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [PIX_W-1:0]  rd_data,
  output logic              pix_valid,
  input  logic              pix_ready,
  output logic [PIX_W-1:0]  pix_data,
  output logic              pix_last,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic              res_hit,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PIX_W-1:0]  wr_data,
  output logic              done
);
  localparam int OFF_W = $clog2(IMG_W * IMG_H);

  scan_state_t state, state_n;

  logic [OFF_W-1:0] win_off;
  logic pos_last, pix_end, mk_fin;
  logic pos_init, pos_adv, pg_load, pg_step, mk_start;

  always_comb begin
    state_n  = state;
    pos_init = 1'b0;
    pos_adv  = 1'b0;
    pg_load  = 1'b0;
    pg_step  = 1'b0;
    mk_start = 1'b0;
    unique case (state)
      ST_IDLE, ST_DONE: if (start) begin
        pos_init = 1'b1;
        state_n  = ST_LOAD;
      end
      ST_LOAD: begin
        pg_load = 1'b1;
        state_n = ST_RD;
      end
      ST_RD:  state_n = ST_CAP;
      ST_CAP: state_n = ST_OUT;
      ST_OUT: if (pix_ready) begin
        if (pix_end) state_n = ST_WAIT;
        else begin
          pg_step = 1'b1;
          state_n = ST_RD;
        end
      end
      ST_WAIT: if (res_valid) begin
        if (res_hit) begin
          mk_start = 1'b1;
          state_n  = ST_MARK;
        end else state_n = ST_NEXT;
      end
      ST_MARK: if (mk_fin) state_n = ST_NEXT;
      ST_NEXT: if (pos_last) state_n = ST_DONE;
      else begin
        pos_adv = 1'b1;
        state_n = ST_LOAD;
      end
      default: state_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      rd_en     <= 1'b0;
      pix_valid <= 1'b0;
      pix_last  <= 1'b0;
      res_ready <= 1'b0;
      done      <= 1'b0;
      pix_data  <= '0;
    end else begin
      state     <= state_n;
      rd_en     <= (state_n == ST_RD);
      pix_valid <= (state_n == ST_OUT);
      pix_last  <= (state_n == ST_OUT) && pix_end;
      res_ready <= (state_n == ST_WAIT);
      done      <= (state_n == ST_DONE);
      if (state == ST_CAP) pix_data <= rd_data;
    end
  end

  wsc_pos_gen #(
    .IMG_W(IMG_W), .IMG_H(IMG_H), .WIN(WIN), .STRIDE(STRIDE), .OFF_W(OFF_W)
  ) u_pos (
    .clk(clk), .rst(rst), .init(pos_init), .adv(pos_adv),
    .win_off(win_off), .last(pos_last)
  );

  wsc_pix_gen #(
    .IMG_W(IMG_W), .WIN(WIN), .ADDR_W(ADDR_W), .OFF_W(OFF_W), .RD_BASE(RD_BASE)
  ) u_pix (
    .clk(clk), .rst(rst), .load(pg_load), .step(pg_step),
    .win_off(win_off), .rd_addr(rd_addr), .last(pix_end)
  );

  wsc_marker #(
    .IMG_W(IMG_W), .WIN(WIN), .ARM(ARM), .ADDR_W(ADDR_W), .OFF_W(OFF_W),
    .WR_BASE(WR_BASE), .PIX_W(PIX_W)
  ) u_mark (
    .clk(clk), .rst(rst), .start(mk_start), .win_off(win_off),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .fin(mk_fin)
  );

  assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
    !(rd_en && wr_en));

  assert_rd_pulse_R8: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> !rd_en);

  assert_pix_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && !pix_ready) |=> (pix_valid && $stable(pix_data) && $stable(pix_last)));

  assert_no_pix_wait_R5: assert property (@(posedge clk) disable iff (rst)
    res_ready |-> !pix_valid);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    done |-> (!rd_en && !wr_en && !pix_valid && !res_ready));
endmodule

// File: tb/win_scan_ctrl_tb.sv
`timescale 1ns/1ps
module win_scan_ctrl_tb;
  localparam int W = 34, H = 29, WIN = 20, S = 4;
  localparam int RDB = 64, WRB = 100, AW = 11;
  localparam int NCOL = 4, NROW = 3, NWIN = 12;

  // Per window: [8] verdict, [7:4] stall length, [3:0] verdict delay
  localparam logic [8:0] VEC [NWIN] = '{
    9'h1_03, 9'h0_21, 9'h0_05, 9'h1_30,
    9'h1_12, 9'h1_04, 9'h0_00, 9'h0_52,
    9'h0_13, 9'h1_00, 9'h0_07, 9'h1_41
  };

  logic clk = 0, rst = 1, start = 0;
  logic rd_en, pix_valid, pix_ready = 0, pix_last;
  logic res_valid = 0, res_ready, res_hit = 0;
  logic wr_en, done;
  logic [AW-1:0] rd_addr, wr_addr;
  logic [7:0] rd_data, pix_data, wr_data;

  logic [7:0] img  [2048];
  logic [7:0] outm [2048];
  logic [7:0] expm [2048];
  int checks = 0, errors = 0, wcnt = 0, rcnt = 0;

  always #4 clk = ~clk;

  win_scan_ctrl u_dut (
    .clk(clk), .rst(rst), .start(start), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .pix_valid(pix_valid), .pix_ready(pix_ready),
    .pix_data(pix_data), .pix_last(pix_last), .res_valid(res_valid),
    .res_ready(res_ready), .res_hit(res_hit), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .done(done)
  );

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data <= img[rd_addr];
      rcnt = rcnt + 1;
    end
    if (wr_en) begin
      outm[wr_addr] <= wr_data;
      wcnt = wcnt + 1;
    end
  end

  function automatic logic [7:0] pval(int y, int x);
    return 8'(x * 5 + y * 11 + 3);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  task automatic run_window(input int i);
    int y0, x0, perr, lerr, serr, rrerr, gap, dly;
    logic [7:0] hold;
    y0 = (i / NCOL) * S;
    x0 = (i % NCOL) * S;
    gap = int'(VEC[i][7:4]);
    dly = int'(VEC[i][3:0]);
    perr = 0; lerr = 0; serr = 0; rrerr = 0;
    for (int p = 0; p < WIN * WIN; p++) begin
      @(negedge clk);
      while (!pix_valid) begin
        if (res_ready) rrerr++;
        @(negedge clk);
      end
      if (pix_data !== pval(y0 + p / WIN, x0 + p % WIN)) perr++;
      if (pix_last !== (p == WIN * WIN - 1)) lerr++;
      if (gap > 0 && (p % 97) == 5) begin
        hold = pix_data;
        for (int g = 0; g < gap; g++) begin
          @(negedge clk);
          if (!pix_valid || pix_data !== hold) serr++;
        end
      end
      if (i == 5 && p == 100) start = 1;   // R10: ignored mid-scan
      pix_ready = 1;
      @(negedge clk);
      pix_ready = 0;
      start = 0;
      if (p != WIN * WIN - 1 && pix_valid) serr++;   // one pixel per transfer
    end
    check(perr == 0, "R2", $sformatf("window %0d pixel mismatches", i), perr, 0);
    check(lerr == 0, "R2", $sformatf("window %0d last flag errors", i), lerr, 0);
    check(serr == 0, "R4", $sformatf("window %0d hold errors", i), serr, 0);
    check(rrerr == 0 && res_ready === 1'b1, "R5",
          $sformatf("window %0d res_ready after last", i), int'(res_ready), 1);
    for (int d = 0; d < dly; d++) begin
      if (pix_valid || rd_en || !res_ready) rrerr++;
      @(negedge clk);
    end
    check(rrerr == 0, "R5", $sformatf("window %0d quiet wait", i), rrerr, 0);
    if (i == NWIN - 1) check(done === 1'b0, "R9", "done before last verdict", int'(done), 0);
    res_valid = 1;
    res_hit = VEC[i][8];
    @(negedge clk);
    res_valid = 0;
    res_hit = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    summary();
  end

  initial begin
    int hits, miss, untouched, cen, qerr;
    for (int a = 0; a < 2048; a++) begin
      img[a] = 8'hEE; outm[a] = 8'h00; expm[a] = 8'h00;
    end
    for (int y = 0; y < H; y++)
      for (int x = 0; x < W; x++) img[RDB + y * W + x] = pval(y, x);

    repeat (4) @(posedge clk);
    @(negedge clk);
    check(!rd_en && !wr_en && !pix_valid && !pix_last && !res_ready && !done,
          "R1", "outputs during reset", int'({rd_en, wr_en, pix_valid, res_ready, done}), 0);
    rst = 0;
    @(negedge clk);
    check(!rd_en && !wr_en && !pix_valid && !res_ready && !done,
          "R1", "outputs after reset", int'({rd_en, wr_en, pix_valid, res_ready, done}), 0);

    start = 1;
    @(negedge clk);
    start = 0;
    for (int i = 0; i < NWIN; i++) run_window(i);

    for (int t = 0; t < 30 && !done; t++) @(negedge clk);
    check(done === 1'b1, "R9", "done after last window", int'(done), 1);
    check(rcnt == NWIN * WIN * WIN, "R3", "window count via reads", rcnt, NWIN * WIN * WIN);
    check(rcnt == NWIN * WIN * WIN, "R8", "each pixel read once", rcnt, NWIN * WIN * WIN);

    hits = 0;
    for (int i = 0; i < NWIN; i++) if (VEC[i][8]) begin
      hits++;
      cen = ((i / NCOL) * S + WIN / 2) * W + (i % NCOL) * S + WIN / 2;
      for (int d = -2; d <= 2; d++) begin
        expm[WRB + cen + d] = 8'hFF;
        expm[WRB + cen + d * W] = 8'hFF;
      end
    end
    check(wcnt == 9 * hits, "R6", "marker write count", wcnt, 9 * hits);
    for (int i = 0; i < NWIN; i++) if (VEC[i][8]) begin
      miss = 0;
      cen = ((i / NCOL) * S + WIN / 2) * W + (i % NCOL) * S + WIN / 2;
      for (int d = -2; d <= 2; d++) begin
        if (outm[WRB + cen + d] !== 8'hFF) miss++;
        if (outm[WRB + cen + d * W] !== 8'hFF) miss++;
      end
      check(miss == 0, "R6", $sformatf("window %0d marker pixels missing", i), miss, 0);
    end
    untouched = 0;
    for (int a = 0; a < 2048; a++)
      if (expm[a] == 8'h00 && outm[a] !== 8'h00) untouched++;
    check(untouched == 0, "R7", "writes outside positive markers", untouched, 0);

    qerr = 0;
    for (int t = 0; t < 20; t++) begin
      @(negedge clk);
      if (!done || rd_en || wr_en || pix_valid) qerr++;
    end
    check(qerr == 0, "R9", "done held and quiet", qerr, 0);

    start = 1;
    @(negedge clk);
    start = 0;
    check(done === 1'b0, "R10", "done falls on restart", int'(done), 0);
    for (int t = 0; t < 10 && !pix_valid; t++) @(negedge clk);
    check(pix_valid === 1'b1 && pix_data === pval(0, 0), "R10",
          "restart first pixel", int'(pix_data), int'(pval(0, 0)));
    summary();
  end
endmodule